// File: doc/BRIEF.md
# Clear-on-Read Ethernet Statistics Counter Bank

This block keeps eleven event tallies for an Ethernet MAC: error, collision and packet-class events on both the receive and the transmit side. The MAC raises a one-cycle strobe for each event. Each tally counts those strobes in its own 32-bit register. A tally stops at all-ones and does not roll over.

Software reads the tallies through a plain read port. Every tally sits at a fixed word inside one 4 KB address window. A read of a tally returns its value one cycle later and clears it in the same access, so each read yields the events since the previous read. The design handles the case where an event lands in the same cycle as the read of its tally: the event is carried into the next count and is not lost. Reads of any other word in the window, and reads outside the window, return zero and change nothing.

Top module: `stat_ctr_bank`

## Requirements
- R1: After a synchronous active-low reset, every tally is zero, `rd_valid` is 0 and `rd_data` is 0.
- R2: Each cycle in which `ev_strobe[k]` is high adds one to tally k, as long as that tally is not being read in that cycle.
- R3: A read request (`rd_en` high at a clock edge) produces `rd_valid` high on the next cycle. In that cycle `rd_data` holds the value the addressed tally had at the request edge.
- R4: Reading a tally resets it to zero when no event for it coincides with the read.
- R5: A tally that holds all-ones stays at all-ones on further events. It does not wrap.
- R6: If `ev_strobe[k]` is high in the same cycle that tally k is read, the read returns the old value and the tally then holds 1.
- R7: The byte offsets from the window base are fixed by event bit:
  - bit 0 (CRC error): 0x000
  - bit 1 (receive error): 0x00C
  - bit 2 (single collision): 0x014
  - bit 3 (excessive collision): 0x018
  - bit 4 (good receive): 0x074
  - bit 5 (broadcast receive): 0x078
  - bit 6 (multicast receive): 0x07C
  - bit 7 (all receives): 0x0D0
  - bit 8 (all transmits): 0x0D4
  - bit 9 (multicast transmit): 0x0F0
  - bit 10 (broadcast transmit): 0x0F4
- R8: A read of an unassigned word inside the window, or of an address that is not 4-byte aligned, returns zero and leaves every tally unchanged.
- R9: A read outside the window 0x4000–0x4FFF (the default base) returns zero and leaves every tally unchanged. This holds even when the low 12 address bits match an assigned offset.
- R10: A single read of every word in the window, in any order and with no events arriving, leaves every tally at zero.
- R11: Reading one tally does not change any other tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_strobe | input | 11 | One-cycle event strobes from the MAC, bit order as in R7 |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W (16) | Byte address of the read |
| rd_data | output | CNT_W (32) | Read result, valid when `rd_valid` is high |
| rd_valid | output | 1 | High one cycle after a read request |

## Verification
The bench builds the bank with an 8-bit tally width and keeps the default 16-bit address and 0x4000 window base. With this width, saturation is reached after 255 strobes, so the hold at all-ones and the read-while-saturated case run in a few hundred cycles instead of billions. The address width is unchanged, so the bench can probe addresses just below the window and above it, including an address above the window whose low 12 bits equal an assigned offset. A full sweep of all 1024 window words exercises every decode path.

// File: rtl/stat_ctr_pkg.sv
// Shared constants for the statistics counter bank: event count,
// window size and the fixed offset of each event's counter.
package stat_ctr_pkg;

    localparam int unsigned N_EV   = 11;
    localparam int unsigned WIN_AW = 12;   // 4 KB window

    typedef enum logic [3:0] {
        EV_CRC_ERR  = 4'd0,
        EV_RX_ERR   = 4'd1,
        EV_SNGL_COL = 4'd2,
        EV_XS_COL   = 4'd3,
        EV_RX_GOOD  = 4'd4,
        EV_RX_BCAST = 4'd5,
        EV_RX_MCAST = 4'd6,
        EV_RX_ALL   = 4'd7,
        EV_TX_ALL   = 4'd8,
        EV_TX_MCAST = 4'd9,
        EV_TX_BCAST = 4'd10
    } ev_id_e;

    // Byte offset inside the window of the counter for event idx.
    function automatic logic [WIN_AW-1:0] ev_offset(input int unsigned idx);
        logic [WIN_AW-1:0] ofs;
        case (idx)
            EV_CRC_ERR:  ofs = 12'h000;
            EV_RX_ERR:   ofs = 12'h00C;
            EV_SNGL_COL: ofs = 12'h014;
            EV_XS_COL:   ofs = 12'h018;
            EV_RX_GOOD:  ofs = 12'h074;
            EV_RX_BCAST: ofs = 12'h078;
            EV_RX_MCAST: ofs = 12'h07C;
            EV_RX_ALL:   ofs = 12'h0D0;
            EV_TX_ALL:   ofs = 12'h0D4;
            EV_TX_MCAST: ofs = 12'h0F0;
            EV_TX_BCAST: ofs = 12'h0F4;
            default:     ofs = 12'hFFC;
        endcase
        return ofs;
    endfunction

endpackage

// File: rtl/stat_addr_decode.sv
// Address decoder for the counter window.
// Assumes: ADDR_W > WIN_AW and WIN_BASE is aligned to the window size.
// Produces at most one select per cycle, and only for an aligned read
// that hits an assigned counter word.
module stat_addr_decode
    import stat_ctr_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [N_EV-1:0]   rd_sel
);

    localparam int unsigned TAG_W = ADDR_W - WIN_AW;

    logic win_hit;

    // Purpose: qualify the request by window tag and word alignment.
    always_comb begin
        win_hit = rd_en
               && (rd_addr[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW])
               && (rd_addr[1:0] == 2'b00);
    end

    for (genvar k = 0; k < N_EV; k++) begin : g_sel
        localparam logic [WIN_AW-1:0] OFS = ev_offset(k);
        // Purpose: match the word index against this counter's offset.
        always_comb begin
            rd_sel[k] = win_hit && (rd_addr[WIN_AW-1:2] == OFS[WIN_AW-1:2]);
        end
    end

    if (TAG_W == 0) begin : g_bad_cfg
        initial $display("stat_addr_decode: ADDR_W must exceed WIN_AW");
    end

endmodule

// File: rtl/stat_counter.sv
// One saturating event counter with clear-on-read.
// Assumes: ev is a one-cycle strobe. rd_clr is high in the cycle its
// value is captured by the read mux.
// An event that coincides with the clear restarts the count at 1.
module stat_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic             rd_clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Purpose: count events, hold at all-ones, clear (or restart) on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (rd_clr) begin
            cnt <= {{(CNT_W-1){1'b0}}, ev};
        end else if (ev && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/stat_rd_mux.sv
// Read-data selector and output register.
// Assumes: rd_sel is one-hot or all zero. A zero select returns zero.
// Data and valid appear one cycle after the request.
module stat_rd_mux #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned N_CNT = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [N_CNT-1:0]            rd_sel,
    input  logic [N_CNT-1:0][CNT_W-1:0] cnt,
    output logic [CNT_W-1:0]            rd_data,
    output logic                        rd_valid
);

    logic [CNT_W-1:0] mux_out;

    // Purpose: AND-OR select of the addressed counter value.
    always_comb begin
        mux_out = '0;
        for (int k = 0; k < N_CNT; k++) begin
            mux_out = mux_out | (cnt[k] & {CNT_W{rd_sel[k]}});
        end
    end

    // Purpose: register the read result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_data  <= rd_en ? mux_out : '0;
            rd_valid <= rd_en;
        end
    end

endmodule

// File: rtl/stat_ctr_bank.sv
// Top of the clear-on-read statistics counter bank.
// Assumes: event strobes are synchronous to clk. Reads are single
// requests with a fixed one-cycle latency and no back-pressure.
module stat_ctr_bank
    import stat_ctr_pkg::*;
#(
    parameter int unsigned       CNT_W    = 32,
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EV-1:0]   ev_strobe,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              rd_valid
);

    logic [N_EV-1:0]            rd_sel;
    logic [N_EV-1:0][CNT_W-1:0] cnt_q;

    stat_addr_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE)
    ) u_dec (
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_sel (rd_sel)
    );

    for (genvar k = 0; k < N_EV; k++) begin : g_cnt
        stat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev_strobe[k]),
            .rd_clr(rd_sel[k]),
            .cnt   (cnt_q[k])
        );
    end

    stat_rd_mux #(.CNT_W(CNT_W), .N_CNT(N_EV)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .cnt     (cnt_q),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

endmodule

// File: rtl/stat_ctr_bank_chk.sv
// Property checker for stat_ctr_bank, attached by bind.
module stat_ctr_bank_chk
    import stat_ctr_pkg::*;
#(
    parameter int unsigned       CNT_W    = 32,
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_EV-1:0]            ev_strobe,
    input logic                       rd_en,
    input logic [ADDR_W-1:0]          rd_addr,
    input logic [CNT_W-1:0]           rd_data,
    input logic                       rd_valid,
    input logic [N_EV-1:0]            rd_sel,
    input logic [N_EV-1:0][CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] MAXV    = '1;
    localparam logic [ADDR_W:0]  WIN_LO  = {1'b0, WIN_BASE};
    localparam logic [ADDR_W:0]  WIN_END = WIN_LO + (ADDR_W+1)'(1 << WIN_AW);

    logic outside;
    assign outside = ({1'b0, rd_addr} < WIN_LO) || ({1'b0, rd_addr} >= WIN_END);

    AST_VALID_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);                                  // R3
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);                                // R3
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_sel));                                    // R7
    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && outside) |=> (rd_data == '0));              // R9
    AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr[1:0] != 2'b00)) |=> (rd_data == '0)); // R8

    for (genvar k = 0; k < N_EV; k++) begin : g_prop
        AST_READ_OLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            rd_sel[k] |=> (rd_data == $past(cnt_q[k])));      // R3
        AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_sel[k] && !ev_strobe[k]) |=> (cnt_q[k] == '0)); // R4
        AST_RACE_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_sel[k] && ev_strobe[k]) |=> (cnt_q[k] == 1)); // R6
        AST_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_sel[k] && ev_strobe[k] && cnt_q[k] != MAXV)
            |=> (cnt_q[k] == $past(cnt_q[k]) + 1'b1));        // R2
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_sel[k] && cnt_q[k] == MAXV) |=> (cnt_q[k] == MAXV)); // R5
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_sel[k] && !ev_strobe[k]) |=> $stable(cnt_q[k])); // R11
    end

endmodule

bind stat_ctr_bank stat_ctr_bank_chk #(
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_strobe(ev_strobe),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_sel   (rd_sel),
    .cnt_q    (cnt_q)
);

// File: tb/stat_ctr_bank_bench.sv
module stat_ctr_bank_bench;

    localparam int CW = 8;
    localparam int AW = 16;
    localparam int NE = 11;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] ev_strobe = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic          rd_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    stat_ctr_bank #(.CNT_W(CW), .ADDR_W(AW), .WIN_BASE(16'h4000)) u_stat_ctr_bank (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Offsets per event bit, as listed in R7.
    function automatic logic [15:0] addr_of(input int k);
        logic [11:0] o;
        case (k)
            0: o = 12'h000; 1: o = 12'h00C; 2: o = 12'h014; 3: o = 12'h018;
            4: o = 12'h074; 5: o = 12'h078; 6: o = 12'h07C; 7: o = 12'h0D0;
            8: o = 12'h0D4; 9: o = 12'h0F0; default: o = 12'h0F4;
        endcase
        return 16'h4000 | {4'h0, o};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int k, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ev_strobe[k] = 1'b1;
        end
        @(negedge clk); ev_strobe = '0;
    endtask

    // Issue one read; optionally raise event evk in the same cycle.
    task automatic do_read(input logic [15:0] a, input int evk, output int data, output int vld);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        if (evk >= 0) ev_strobe[evk] = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; ev_strobe = '0;
        data = int'(rd_data); vld = int'(rd_valid);
    endtask

    task automatic t_reset();
        int d, v;
        check("R1 valid", int'(rd_valid), 0);
        check("R1 data", int'(rd_data), 0);
        for (int k = 0; k < NE; k++) begin
            do_read(addr_of(k), -1, d, v);
            check("R1 counter", d, 0);
        end
    endtask

    task automatic t_map_count_clear();
        int d, v;
        for (int k = 0; k < NE; k++) pulse(k, k + 3);
        for (int k = 0; k < NE; k++) begin
            do_read(addr_of(k), -1, d, v);
            check("R3 valid", v, 1);
            check("R2/R7 count at offset", d, k + 3);
        end
        for (int k = 0; k < NE; k++) begin
            do_read(addr_of(k), -1, d, v);
            check("R4 cleared", d, 0);
        end
    endtask

    task automatic t_isolation();
        int d, v;
        pulse(0, 5); pulse(1, 7);
        do_read(addr_of(0), -1, d, v); check("R11 first", d, 5);
        do_read(addr_of(1), -1, d, v); check("R11 other kept", d, 7);
    endtask

    task automatic t_saturate();
        int d, v;
        pulse(2, 300);
        do_read(addr_of(2), -1, d, v); check("R5 saturated", d, MAXV);
        pulse(2, 260);
        do_read(addr_of(2), 2, d, v); check("R5 read while saturated", d, MAXV);
        do_read(addr_of(2), -1, d, v); check("R6 restart after sat", d, 1);
    endtask

    task automatic t_race();
        int d, v;
        pulse(3, 4);
        do_read(addr_of(3), 3, d, v); check("R6 old value", d, 4);
        do_read(addr_of(3), -1, d, v); check("R6 restart at one", d, 1);
    endtask

    task automatic t_unassigned();
        int d, v;
        pulse(4, 6);
        do_read(16'h4004, -1, d, v); check("R8 hole", d, 0);
        do_read(16'h4070, -1, d, v); check("R8 hole", d, 0);
        do_read(16'h4075, -1, d, v); check("R8 misaligned", d, 0);
        do_read(addr_of(4), -1, d, v); check("R8 untouched", d, 6);
    endtask

    task automatic t_outside();
        int d, v;
        pulse(5, 2);
        do_read(16'h3FFC, -1, d, v); check("R9 below", d, 0);
        check("R9 valid", v, 1);
        do_read(16'h5078, -1, d, v); check("R9 alias above", d, 0);
        do_read(addr_of(5), -1, d, v); check("R9 untouched", d, 2);
    endtask

    task automatic t_sweep();
        int d, v, exp;
        for (int k = 0; k < NE; k++) pulse(k, 1 + (k % 4));
        for (int w = 0; w < 1024; w++) begin
            exp = 0;
            for (int k = 0; k < NE; k++)
                if (addr_of(k) == 16'h4000 + 16'(w * 4)) exp = 1 + (k % 4);
            do_read(16'h4000 + 16'(w * 4), -1, d, v);
            check("R10 sweep value", d, exp);
        end
        for (int k = 0; k < NE; k++) begin
            do_read(addr_of(k), -1, d, v);
            check("R10 all zero after sweep", d, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map_count_clear();
        t_isolation();
        t_saturate();
        t_race();
        t_unassigned();
        t_outside();
        t_sweep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule